// File: doc/BRIEF.md
# Time-Slot Chip-Select Sequencer

This block lets plain serial converters share a frame-synchronised, time-slotted synchronous serial port. Such a port carries separate data-in, data-out and clock lines. A frame-sync marks the start of each full cycle, and the cycle is split into time slots. Whichever device owns a slot raises a slot-start strobe for the next device once its own transfer is done. The converters behind this block do not follow slot strobes. Each one instead needs its chip select held low for its whole word.

The sequencer runs on the serial clock and counts on the rising edge, which is the edge the converters sample on. It waits for the slot-start strobe handed on by the upstream device. It then drives one chip-select window for an ADC, followed at once by one window for each DAC in turn. Each window lasts exactly one word. After the last DAC window it passes a one-period slot-start strobe downstream, so more devices can be chained behind it. To the host, the converter group looks like one more multi-slot device.

A strobe that arrives while a sequence is running does not disturb the sequence. Instead it sets a sticky overlap flag.

Top module: `tsslot_cs_seq`

## Requirements
- R1: A synchronous active-low reset, sampled on a rising `sclk` edge, drives all chip selects high, `slotStartOut` low and `overlapErr` low from the next period on.
- R2: When `slotStartIn` is high at a rising `sclk` edge and no window is open, `adcSelN` goes low in the period right after that edge.
- R3: Every chip-select window stays low for exactly `WORD_BITS` consecutive `sclk` periods and goes high in the period after that.
- R4: The windows follow a fixed order: ADC first, then `dacSelN[0]`, then `dacSelN[1]`, and so on. Each DAC window opens in the same period that the previous window closes. At no time is more than one select low.
- R5: `slotStartOut` is high for exactly one `sclk` period: the period in which the last DAC select has just returned high. It is low at all other times.
- R6: A `slotStartIn` pulse seen at any edge while a window is open leaves the running sequence unchanged and starts no new sequence afterwards. This includes the edge that closes the last window.
- R7: Such an ignored pulse sets `overlapErr` in the period after that edge. The flag stays set until reset.
- R8: A `slotStartIn` pulse at the edge that starts the `slotStartOut` period's successor is accepted immediately: a strobe sampled during the `slotStartOut` period opens a new ADC window without setting `overlapErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| slotStartIn | input | 1 | Slot-start strobe from the upstream device |
| adcSelN | output | 1 | ADC chip select, active low |
| dacSelN | output | NUM_DAC | DAC chip selects, active low, bit 0 served first |
| slotStartOut | output | 1 | One-period slot-start strobe for the next device in the chain |
| overlapErr | output | 1 | Sticky flag: a strobe arrived while a sequence was running |

## Verification
The bench builds the block with `WORD_BITS` = 4 and `NUM_DAC` = 2, so a whole sequence is only twelve periods long. This short word lets the bench sweep a colliding strobe across every busy edge of the sequence, from the first bit of the ADC window to the edge that closes the last DAC window. For each of those offsets it compares all selects, the chained strobe and the overlap flag period by period against arithmetic expectations. The same small setup also makes it cheap to test the boundary where the strobe lands on the first idle edge, as well as a reset in the middle of a sequence.

// File: rtl/tsslot_pkg.sv
package tsslot_pkg;
  // Strobes from the control FSM to the datapath, one cycle wide each.
  typedef struct packed {
    logic load;     // open the first (ADC) window
    logic step;     // close current window, open the next one
    logic finish;   // close the last window and pulse the chain strobe
    logic collide;  // a slot strobe arrived while busy
  } seqStrobes_t;
endpackage

// File: rtl/tsslot_ctrl.sv
module tsslot_ctrl
  import tsslot_pkg::*;
(
  input  logic        sclk,
  input  logic        rstN,
  input  logic        slotStartIn,
  input  logic        lastBit,
  input  logic        lastSlot,
  output seqStrobes_t strobes
);
  typedef enum logic {ST_IDLE, ST_RUN} seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (slotStartIn) begin
          strobes.load = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      ST_RUN: begin
        strobes.collide = slotStartIn;
        if (lastBit) begin
          if (lastSlot) begin
            strobes.finish = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            strobes.step = 1'b1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge sclk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/tsslot_datapath.sv
module tsslot_datapath
  import tsslot_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int NUM_CONV  = 3
) (
  input  logic                sclk,
  input  logic                rstN,
  input  seqStrobes_t         strobes,
  output logic                lastBit,
  output logic                lastSlot,
  output logic [NUM_CONV-1:0] selN,
  output logic                slotStartOut,
  output logic                overlapErr
);
  localparam int BIT_W  = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam int SLOT_W = (NUM_CONV > 1) ? $clog2(NUM_CONV) : 1;

  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotIdx;
  logic [SLOT_W-1:0] slotNext;
  logic              windowOpen;

  assign windowOpen = ~&selN;
  assign lastBit    = (bitCnt == BIT_W'(WORD_BITS - 1));
  assign lastSlot   = (slotIdx == SLOT_W'(NUM_CONV - 1));
  assign slotNext   = slotIdx + 1'b1;

  // Bit and slot counters.
  always_ff @(posedge sclk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      slotIdx <= '0;
    end else if (strobes.load || strobes.finish) begin
      bitCnt  <= '0;
      slotIdx <= '0;
    end else if (strobes.step) begin
      bitCnt  <= '0;
      slotIdx <= slotNext;
    end else if (windowOpen) begin
      bitCnt  <= bitCnt + 1'b1;
    end
  end

  // One registered select per converter; index 0 is the ADC.
  for (genvar i = 0; i < NUM_CONV; i++) begin : gSel
    always_ff @(posedge sclk) begin
      if (!rstN)               selN[i] <= 1'b1;
      else if (strobes.load)   selN[i] <= (i != 0);
      else if (strobes.step)   selN[i] <= (slotNext != SLOT_W'(i));
      else if (strobes.finish) selN[i] <= 1'b1;
    end
  end

  always_ff @(posedge sclk) begin
    if (!rstN) begin
      slotStartOut <= 1'b0;
      overlapErr   <= 1'b0;
    end else begin
      slotStartOut <= strobes.finish;
      overlapErr   <= overlapErr | strobes.collide;
    end
  end
endmodule

// File: rtl/tsslot_cs_seq.sv
module tsslot_cs_seq
  import tsslot_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int NUM_DAC   = 2
) (
  input  logic               sclk,
  input  logic               rstN,
  input  logic               slotStartIn,
  output logic               adcSelN,
  output logic [NUM_DAC-1:0] dacSelN,
  output logic               slotStartOut,
  output logic               overlapErr
);
  localparam int NUM_CONV = NUM_DAC + 1;

  seqStrobes_t         strobes;
  logic                lastBit;
  logic                lastSlot;
  logic [NUM_CONV-1:0] selN;

  tsslot_ctrl uCtrl (
    .sclk        (sclk),
    .rstN        (rstN),
    .slotStartIn (slotStartIn),
    .lastBit     (lastBit),
    .lastSlot    (lastSlot),
    .strobes     (strobes)
  );

  tsslot_datapath #(
    .WORD_BITS (WORD_BITS),
    .NUM_CONV  (NUM_CONV)
  ) uPath (
    .sclk         (sclk),
    .rstN         (rstN),
    .strobes      (strobes),
    .lastBit      (lastBit),
    .lastSlot     (lastSlot),
    .selN         (selN),
    .slotStartOut (slotStartOut),
    .overlapErr   (overlapErr)
  );

  assign adcSelN = selN[0];
  assign dacSelN = selN[NUM_CONV-1:1];
endmodule

// File: rtl/tsslot_cs_seq_chk.sv
module tsslot_cs_seq_chk #(
  parameter int WORD_BITS = 16,
  parameter int NUM_DAC   = 2
) (
  input logic               sclk,
  input logic               rstN,
  input logic               slotStartIn,
  input logic               adcSelN,
  input logic [NUM_DAC-1:0] dacSelN,
  input logic               slotStartOut,
  input logic               overlapErr
);
  localparam int NUM_CONV = NUM_DAC + 1;
  localparam int CNT_W    = $clog2(WORD_BITS + 2) + 1;

  logic [NUM_CONV-1:0] selAll;
  assign selAll = {dacSelN, adcSelN};

  AST_RESET_IDLE: assert property (@(posedge sclk)
    !rstN |=> (&selAll && !slotStartOut && !overlapErr)); // R1

  AST_START_ADC: assert property (@(posedge sclk) disable iff (!rstN)
    (&selAll && slotStartIn) |=> !adcSelN); // R2

  AST_ONE_SELECT: assert property (@(posedge sclk) disable iff (!rstN)
    $onehot0(~selAll)); // R4

  AST_CHAIN_PULSE: assert property (@(posedge sclk) disable iff (!rstN)
    slotStartOut |=> !slotStartOut); // R5

  AST_CHAIN_AFTER_LAST: assert property (@(posedge sclk) disable iff (!rstN)
    (slotStartOut && $past(rstN)) |-> $past(!dacSelN[NUM_DAC-1])); // R5

  AST_OVERLAP_STICKY: assert property (@(posedge sclk) disable iff (!rstN)
    overlapErr |=> overlapErr); // R7

  // Window length, tracked with a run counter per select.
  for (genvar i = 0; i < NUM_CONV; i++) begin : gLen
    logic [CNT_W-1:0] lowCnt;
    always_ff @(posedge sclk) begin
      if (!rstN || selAll[i]) lowCnt <= '0;
      else                    lowCnt <= lowCnt + 1'b1;
    end
    AST_WINDOW_LEN: assert property (@(posedge sclk) disable iff (!rstN)
      ($rose(selAll[i]) && $past(rstN)) |-> (lowCnt == CNT_W'(WORD_BITS))); // R3
  end
endmodule

bind tsslot_cs_seq tsslot_cs_seq_chk #(
  .WORD_BITS (WORD_BITS),
  .NUM_DAC   (NUM_DAC)
) uChk (
  .sclk         (sclk),
  .rstN         (rstN),
  .slotStartIn  (slotStartIn),
  .adcSelN      (adcSelN),
  .dacSelN      (dacSelN),
  .slotStartOut (slotStartOut),
  .overlapErr   (overlapErr)
);

// File: tb/sim_tsslot_cs_seq.sv
module sim_tsslot_cs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int ND         = 2;
  localparam int NC         = ND + 1;
  localparam int TOTAL      = W * NC;
  localparam int WATCHDOG   = 20000;

  logic          sclk = 1'b0;
  logic          rstN = 1'b0;
  logic          strb = 1'b0;
  logic          adcSelN;
  logic [ND-1:0] dacSelN;
  logic          chainOut;
  logic          errFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD / 2) sclk = ~sclk;

  tsslot_cs_seq #(.WORD_BITS(W), .NUM_DAC(ND)) u0 (
    .sclk         (sclk),
    .rstN         (rstN),
    .slotStartIn  (strb),
    .adcSelN      (adcSelN),
    .dacSelN      (dacSelN),
    .slotStartOut (chainOut),
    .overlapErr   (errFlag)
  );

  function automatic logic [NC-1:0] expSel(int n);
    logic [NC-1:0] v = '1;
    if (n >= 0 && n < TOTAL) v[n / W] = 1'b0;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge sclk) rstN = 1'b0;
    repeat (2) @(negedge sclk);
    rstN = 1'b1;
  endtask

  // Start a sequence; returns at the sample point right after the accepting edge.
  task automatic pulseStart();
    @(negedge sclk) strb = 1'b1;
    @(negedge sclk) strb = 1'b0;
  endtask

  // Walk one sequence, optionally injecting a strobe at edge k+injectAt.
  task automatic runSeq(input int injectAt);
    string tagSel;
    pulseStart();
    for (int n = 0; n <= TOTAL + 3; n++) begin
      if (injectAt >= 0)        tagSel = "R6";
      else if (n == 0)          tagSel = "R2";
      else if (n % W == 0)      tagSel = "R4";
      else                      tagSel = "R3";
      check(tagSel, 32'({dacSelN, adcSelN}), 32'(expSel(n)));
      check("R5", 32'(chainOut), 32'(n == TOTAL));
      check("R7", 32'(errFlag), 32'(injectAt >= 0 && n >= injectAt));
      strb = (n + 1 == injectAt);
      @(negedge sclk);
    end
    strb = 1'b0;
  endtask

  initial begin
    doReset();
    // R1: state right after reset
    check("R1", 32'({dacSelN, adcSelN}), 32'({NC{1'b1}}));
    check("R1", 32'(chainOut), 32'd0);
    check("R1", 32'(errFlag), 32'd0);

    // Clean sequences (R2, R3, R4, R5)
    runSeq(-1);
    runSeq(-1);

    // Collision at every busy edge (R6, R7)
    for (int m = 1; m <= TOTAL; m++) begin
      runSeq(m);
      doReset();
    end

    // R8: strobe sampled during the chain-strobe period starts a new sequence
    pulseStart();
    for (int n = 0; n < TOTAL; n++) @(negedge sclk);
    check("R8", 32'(chainOut), 32'd1);
    strb = 1'b1;
    @(negedge sclk) strb = 1'b0;
    check("R8", 32'({dacSelN, adcSelN}), 32'(expSel(0)));
    check("R8", 32'(errFlag), 32'd0);
    for (int n = 1; n <= TOTAL; n++) begin
      @(negedge sclk);
      check("R8", 32'({dacSelN, adcSelN}), 32'(expSel(n)));
    end
    check("R8", 32'(chainOut), 32'd1);

    // R1: reset in the middle of a sequence with the flag set
    pulseStart();
    strb = 1'b1;
    @(negedge sclk) strb = 1'b0;
    repeat (W) @(negedge sclk);
    check("R7", 32'(errFlag), 32'd1);
    rstN = 1'b0;
    @(negedge sclk);
    check("R1", 32'({dacSelN, adcSelN}), 32'({NC{1'b1}}));
    check("R1", 32'(chainOut), 32'd0);
    check("R1", 32'(errFlag), 32'd0);
    rstN = 1'b1;
    repeat (TOTAL) @(negedge sclk);
    check("R1", 32'({dacSelN, adcSelN}), 32'({NC{1'b1}}));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge sclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule